// File: doc/BRIEF.md
# Arbitrated SRAM Access Window

This block gives a host on a byte-wide register bus a way into a word-organised SRAM that an internal engine normally owns. The host sets a request bit and polls a status flag until the engine has handed over the memory. It then programs a 16-bit word address and a transfer direction, and moves data one byte at a time through a four-byte write window or a four-byte read window. Clearing the request returns the SRAM to the engine. Each change of ownership, in either direction, raises a one-cycle interrupt pulse.

A write can start at any byte lane. Writing the highest lane commits the assembled word, and only the lanes written since the last commit change. Burst mode steps the word address after each full word, in both directions, so that transfers longer than four bytes run without reprogramming. Word addresses below the SRAM base, or past its last word, are refused and leave the SRAM untouched.

Top module: `sram_window`

## Requirements
- R1: After reset the ownership flag (status offset 0x10, bit 0) reads 0, the request register (offset 0x40) reads 0, the interrupt is low and the engine port reports access allowed.
- R2: Writing 1 to bit 7 of offset 0x40 grants the SRAM to the host no later than RELEASE_CYC+1 cycles after the register write. Status bit 0 then reads 1, and reading the status register has no side effect.
- R3: Writing 0 to bit 7 of offset 0x40 drops the grant one cycle later, and status bit 0 reads 0 again.
- R4: `mem_irq` pulses high for exactly one cycle when the grant is given and for one cycle when it is revoked.
- R5: The engine port writes and reads the SRAM only while the host holds no grant. While the host is granted, `eng_ok` is 0, `eng_rdata` is 0 and engine writes are dropped.
- R6: Writing the address low byte (0x42) or high byte (0x43) loads the addressed word into the read window, with byte k at offset 0x4C+k, one cycle after the write.
- R7: Bytes written to offsets 0x48+k (k = 0..3) fill lane k of a staging word. Writing offset 0x4B commits it, and only the lanes written since the previous commit change, so a transfer can start at lane 1, 2 or 3.
- R8: A commit updates the SRAM only when the write-enable bit (offset 0x41, bit 6) is set. A control value of 0 selects a single read.
- R9: A word address below WIN_BASE (default 0x400) or at or above WIN_BASE+DEPTH is rejected. Commits to it change no SRAM word, and its read window reads 0.
- R10: When the burst bit (offset 0x41, bit 7) is set, the word address increments by one after a write to offset 0x4B or a read of offset 0x4F, and the next word is fetched. Without burst the address holds.
- R11: Without a grant, host commits are dropped and the read window reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the read side effects) |
| reg_addr | input | 8 | Local register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| mem_irq | output | 1 | One-cycle pulse on each grant or revoke |
| eng_en | input | 1 | Engine SRAM access enable |
| eng_we | input | 1 | Engine write (full word) |
| eng_idx | input | IDX_W | Engine word index |
| eng_wdata | input | 32 | Engine write word |
| eng_rdata | output | 32 | Engine read word, 0 while the host owns the SRAM |
| eng_ok | output | 1 | Engine may use the SRAM |

## Verification
On every cycle the assertions check the ownership handshake. A grant appears only under a pending request and within the release window, it falls one cycle after the request is withdrawn, and each edge of the grant comes with an interrupt pulse and no pulse comes without one. They also check that the word address holds when burst is off and no address byte is written. Only the bench scenarios can show the data path: lane-selective merging, the effect of the write-enable bit, rejection of out-of-range addresses, burst stepping over several words, and the engine being locked out during a grant. Each of these is visible only through the values that come back through the read window.

// File: rtl/sram_window_pkg.sv
package sram_window_pkg;
   localparam logic [7:0] OFS_STATUS = 8'h10;
   localparam logic [7:0] OFS_CFG    = 8'h40;
   localparam logic [7:0] OFS_CTL    = 8'h41;
   localparam logic [7:0] OFS_ADR_LO = 8'h42;
   localparam logic [7:0] OFS_ADR_HI = 8'h43;
   localparam logic [7:0] OFS_WR_WIN = 8'h48;
   localparam logic [7:0] OFS_RD_WIN = 8'h4C;
   localparam int         LANES      = 4;

   typedef enum logic [1:0] {
      ARB_IDLE,
      ARB_WAIT,
      ARB_OWN
   } arb_state_e;
endpackage

// File: rtl/sram_window_arb.sv
module sram_window_arb
   import sram_window_pkg::*;
#(
   parameter int RELEASE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic gnt,
   output logic irq
);
   localparam int CNT_W = $clog2(RELEASE_CYC + 1);

   arb_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             gnt_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ARB_IDLE;
         cnt   <= '0;
         gnt_d <= 1'b0;
      end else begin
         gnt_d <= gnt;
         case (state)
            ARB_IDLE: if (req) begin
               state <= ARB_WAIT;
               cnt   <= '0;
            end
            ARB_WAIT: begin
               if (!req) state <= ARB_IDLE;
               else if (cnt == CNT_W'(RELEASE_CYC - 1)) state <= ARB_OWN;
               else cnt <= cnt + 1'b1;
            end
            ARB_OWN: if (!req) state <= ARB_IDLE;
            default: state <= ARB_IDLE;
         endcase
      end
   end

   assign gnt = (state == ARB_OWN);
   assign irq = gnt ^ gnt_d;
endmodule

// File: rtl/sram_window_mem.sv
module sram_window_mem
   import sram_window_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic [LANES-1:0]   we,
   input  logic [IDX_W-1:0]   widx,
   input  logic [8*LANES-1:0] wdata,
   input  logic [IDX_W-1:0]   ridx_a,
   output logic [8*LANES-1:0] rdata_a,
   input  logic [IDX_W-1:0]   ridx_b,
   output logic [8*LANES-1:0] rdata_b
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (we[l]) cells[widx] <= wdata[8*l +: 8];
      end
      assign rdata_a[8*l +: 8] = cells[ridx_a];
      assign rdata_b[8*l +: 8] = cells[ridx_b];
   end
endmodule

// File: rtl/sram_window_regs.sv
module sram_window_regs
   import sram_window_pkg::*;
#(
   parameter int          DEPTH    = 64,
   parameter int          IDX_W    = $clog2(DEPTH),
   parameter logic [15:0] WIN_BASE = 16'h0400
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [7:0]         reg_addr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   input  logic               gnt,
   output logic               req,
   output logic               burst,
   output logic [15:0]        addr,
   output logic [LANES-1:0]   h_we,
   output logic [IDX_W-1:0]   h_idx,
   output logic [8*LANES-1:0] h_wdata,
   input  logic [8*LANES-1:0] h_rdata
);
   localparam int TOP_WORD = int'(WIN_BASE) + DEPTH;

   logic               wren;
   logic [LANES-2:0]   mask;
   logic [8*LANES-9:0] wbuf;
   logic [8*LANES-1:0] rbuf;
   logic               fetch;
   logic               in_range;
   logic               commit;
   logic               rd_last;
   logic               step;

   assign in_range = (addr >= WIN_BASE) && (int'(addr) < TOP_WORD);
   assign h_idx    = IDX_W'(addr - WIN_BASE);
   assign commit   = reg_wr && (reg_addr == OFS_WR_WIN + 8'(LANES - 1));
   assign rd_last  = reg_rd && (reg_addr == OFS_RD_WIN + 8'(LANES - 1));
   assign step     = burst && (commit || rd_last);
   assign h_wdata  = {reg_wdata, wbuf};
   assign h_we     = (commit && wren && gnt && in_range) ? {1'b1, mask} : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req   <= 1'b0;
         burst <= 1'b0;
         wren  <= 1'b0;
         addr  <= '0;
         mask  <= '0;
         wbuf  <= '0;
         rbuf  <= '0;
         fetch <= 1'b0;
      end else begin
         fetch <= 1'b0;
         if (fetch) rbuf <= (gnt && in_range) ? h_rdata : '0;
         if (reg_wr) begin
            case (reg_addr)
               OFS_CFG: req <= reg_wdata[7];
               OFS_CTL: begin
                  burst <= reg_wdata[7];
                  wren  <= reg_wdata[6];
               end
               OFS_ADR_LO: begin
                  addr[7:0] <= reg_wdata;
                  mask      <= '0;
                  fetch     <= 1'b1;
               end
               OFS_ADR_HI: begin
                  addr[15:8] <= reg_wdata;
                  mask       <= '0;
                  fetch      <= 1'b1;
               end
               default: ;
            endcase
            for (int k = 0; k < LANES - 1; k++) begin
               if (reg_addr == OFS_WR_WIN + 8'(k)) begin
                  wbuf[8*k +: 8] <= reg_wdata;
                  mask[k]        <= 1'b1;
               end
            end
         end
         if (commit) begin
            mask  <= '0;
            fetch <= 1'b1;
         end
         if (step) begin
            addr  <= addr + 16'd1;
            fetch <= 1'b1;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_STATUS: reg_rdata = {7'd0, gnt};
         OFS_CFG:    reg_rdata = {req, 7'd0};
         OFS_CTL:    reg_rdata = {burst, wren, 6'd0};
         OFS_ADR_LO: reg_rdata = addr[7:0];
         OFS_ADR_HI: reg_rdata = addr[15:8];
         default: begin
            for (int k = 0; k < LANES; k++)
               if (reg_addr == OFS_RD_WIN + 8'(k)) reg_rdata = rbuf[8*k +: 8];
         end
      endcase
   end
endmodule

// File: rtl/sram_window.sv
module sram_window
   import sram_window_pkg::*;
#(
   parameter int          DEPTH       = 64,
   parameter int          IDX_W       = $clog2(DEPTH),
   parameter int          RELEASE_CYC = 4,
   parameter logic [15:0] WIN_BASE    = 16'h0400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [7:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   output logic             mem_irq,
   input  logic             eng_en,
   input  logic             eng_we,
   input  logic [IDX_W-1:0] eng_idx,
   input  logic [31:0]      eng_wdata,
   output logic [31:0]      eng_rdata,
   output logic             eng_ok
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("sram_window: DEPTH must be at least 2");
   end
   if (RELEASE_CYC < 1) begin : g_bad_release
      $error("sram_window: RELEASE_CYC must be at least 1");
   end
   if (int'(WIN_BASE) + DEPTH > 65536) begin : g_bad_base
      $error("sram_window: window exceeds 16-bit word space");
   end
   if (IDX_W < $clog2(DEPTH)) begin : g_bad_idx
      $error("sram_window: IDX_W too narrow for DEPTH");
   end

   logic               host_req;
   logic               host_gnt;
   logic               burst_on;
   logic [15:0]        win_addr;
   logic [LANES-1:0]   h_we;
   logic [IDX_W-1:0]   h_idx;
   logic [8*LANES-1:0] h_wdata;
   logic [8*LANES-1:0] h_rdata;
   logic [8*LANES-1:0] e_rdata;
   logic [LANES-1:0]   m_we;
   logic [IDX_W-1:0]   m_widx;
   logic [8*LANES-1:0] m_wdata;

   sram_window_arb #(.RELEASE_CYC(RELEASE_CYC)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(host_req), .gnt(host_gnt), .irq(mem_irq)
   );

   sram_window_regs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .gnt(host_gnt), .req(host_req), .burst(burst_on), .addr(win_addr),
      .h_we(h_we), .h_idx(h_idx), .h_wdata(h_wdata), .h_rdata(h_rdata)
   );

   assign eng_ok    = ~host_gnt;
   assign m_we      = host_gnt ? h_we : ((eng_en && eng_we) ? '1 : '0);
   assign m_widx    = host_gnt ? h_idx : eng_idx;
   assign m_wdata   = host_gnt ? h_wdata : eng_wdata;
   assign eng_rdata = host_gnt ? '0 : e_rdata;

   sram_window_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
      .clk(clk), .we(m_we), .widx(m_widx), .wdata(m_wdata),
      .ridx_a(h_idx), .rdata_a(h_rdata), .ridx_b(eng_idx), .rdata_b(e_rdata)
   );
endmodule

// File: rtl/sram_window_chk.sv
module sram_window_chk #(
   parameter int RELEASE_CYC = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req,
   input logic        gnt,
   input logic        irq,
   input logic        burst,
   input logic [15:0] addr,
   input logic        reg_wr,
   input logic [7:0]  reg_addr
);
   logic [15:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_cnt <= '0;
      else if (req && !gnt) wait_cnt <= (wait_cnt == 16'hFFFF) ? wait_cnt : wait_cnt + 16'd1;
      else wait_cnt <= '0;
   end

   // R2
   grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt) |-> req);

   // R2
   grant_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !gnt) |-> (int'(wait_cnt) < RELEASE_CYC + 1));

   // R3
   revoke_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt && !req) |=> !gnt);

   // R4
   irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt) |-> irq);

   // R4
   irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gnt) |-> irq);

   // R4
   irq_only_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (gnt != $past(gnt)));

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst && !(reg_wr && (reg_addr == 8'h42 || reg_addr == 8'h43))) |=> $stable(addr));
endmodule

bind sram_window sram_window_chk #(.RELEASE_CYC(RELEASE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(host_req), .gnt(host_gnt), .irq(mem_irq),
   .burst(burst_on), .addr(win_addr), .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/sram_window_bench.sv
module sram_window_bench;
   localparam int DEPTH = 64;
   localparam int IDX_W = 6;
   localparam int REL   = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic             reg_rd = 1'b0;
   logic [7:0]       reg_addr = '0;
   logic [7:0]       reg_wdata = '0;
   logic [7:0]       reg_rdata;
   logic             mem_irq;
   logic             eng_en = 1'b0;
   logic             eng_we = 1'b0;
   logic [IDX_W-1:0] eng_idx = '0;
   logic [31:0]      eng_wdata = '0;
   logic [31:0]      eng_rdata;
   logic             eng_ok;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;

   always #4 clk = ~clk;

   sram_window #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RELEASE_CYC(REL)) u_sram_window (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_irq(mem_irq), .eng_en(eng_en), .eng_we(eng_we), .eng_idx(eng_idx),
      .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_ok(eng_ok)
   );

   always @(negedge clk) if (rst_n && mem_irq) irq_cnt++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic set_addr(input logic [15:0] a);
      wr(8'h42, a[7:0]);
      wr(8'h43, a[15:8]);
   endtask

   task automatic read_win(output logic [31:0] w);
      logic [7:0] b;
      for (int k = 0; k < 4; k++) begin
         rd(8'h4C + 8'(k), b);
         w[8*k +: 8] = b;
      end
   endtask

   task automatic write_lanes(input int first, input logic [31:0] w);
      for (int k = first; k < 4; k++) wr(8'h48 + 8'(k), w[8*k +: 8]);
   endtask

   task automatic eng_write(input logic [IDX_W-1:0] i, input logic [31:0] w);
      @(negedge clk);
      eng_en = 1'b1; eng_we = 1'b1; eng_idx = i; eng_wdata = w;
      @(negedge clk);
      eng_en = 1'b0; eng_we = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] b;
      rd(8'h10, b); chk("R1 status", 32'(b), 32'h0);
      rd(8'h40, b); chk("R1 cfg", 32'(b), 32'h0);
      chk("R1 irq", 32'(mem_irq), 32'h0);
      chk("R1 eng_ok", 32'(eng_ok), 32'h1);
   endtask

   task automatic t_grant(input int irq_exp);
      logic [7:0] b;
      int polls = 0;
      wr(8'h40, 8'h80);
      b = 8'h0;
      while (b[0] !== 1'b1 && polls < REL + 4) begin
         rd(8'h10, b);
         polls++;
      end
      chk("R2 granted", 32'(b[0]), 32'h1);
      chk("R2 grant latency ok", 32'(polls <= REL + 2), 32'h1);
      rd(8'h10, b); chk("R2 status read no side effect", 32'(b), 32'h1);
      chk("R4 irq count on grant", 32'(irq_cnt), 32'(irq_exp));
      chk("R5 eng_ok low while granted", 32'(eng_ok), 32'h0);
   endtask

   task automatic t_release(input int irq_exp);
      logic [7:0] b;
      wr(8'h40, 8'h00);
      rd(8'h10, b); chk("R3 grant dropped", 32'(b), 32'h0);
      chk("R4 irq count on revoke", 32'(irq_cnt), 32'(irq_exp));
      chk("R5 eng_ok back", 32'(eng_ok), 32'h1);
   endtask

   task automatic t_engine;
      logic [31:0] w;
      @(negedge clk);
      eng_idx = 6'd5;
      #1 chk("R5 engine sees own write", eng_rdata, 32'hA5A5_5A5A);
      t_grant(1);
      wr(8'h41, 8'h00);
      set_addr(16'h0405);
      read_win(w); chk("R6 host reads engine word", w, 32'hA5A5_5A5A);
      eng_write(6'd5, 32'h1111_1111);
      @(negedge clk);
      eng_idx = 6'd5;
      #1 chk("R5 eng_rdata zero while granted", eng_rdata, 32'h0);
      set_addr(16'h0405);
      read_win(w); chk("R5 engine write dropped", w, 32'hA5A5_5A5A);
   endtask

   task automatic t_lanes;
      logic [31:0] w;
      wr(8'h41, 8'h40);
      set_addr(16'h0406);
      write_lanes(0, 32'h4433_2211);
      read_win(w); chk("R7 full word", w, 32'h4433_2211);
      write_lanes(2, 32'hBBAA_0000);
      read_win(w); chk("R7 start lane 2", w, 32'hBBAA_2211);
      write_lanes(3, 32'hCC00_0000);
      read_win(w); chk("R7 start lane 3", w, 32'hCCAA_2211);
      wr(8'h41, 8'h00);
      write_lanes(0, 32'hDEAD_BEEF);
      set_addr(16'h0406);
      read_win(w); chk("R8 no write enable", w, 32'hCCAA_2211);
   endtask

   task automatic t_range;
      logic [31:0] w;
      wr(8'h41, 8'h40);
      set_addr(16'h043F);
      write_lanes(0, 32'hCAFE_F00D);
      set_addr(16'h03FF);
      write_lanes(0, 32'h0102_0304);
      read_win(w); chk("R9 below base reads zero", w, 32'h0);
      set_addr(16'h0440);
      write_lanes(0, 32'h0506_0708);
      read_win(w); chk("R9 past end reads zero", w, 32'h0);
      set_addr(16'h043F);
      read_win(w); chk("R9 neighbour untouched", w, 32'hCAFE_F00D);
   endtask

   task automatic t_burst;
      logic [31:0] w;
      logic [7:0]  b;
      wr(8'h41, 8'hC0);
      set_addr(16'h0410);
      write_lanes(0, 32'h1357_9BDF);
      write_lanes(0, 32'h2468_ACE0);
      rd(8'h42, b); chk("R10 burst write step", 32'(b), 32'h12);
      wr(8'h41, 8'h80);
      set_addr(16'h0410);
      read_win(w); chk("R10 burst word 0", w, 32'h1357_9BDF);
      read_win(w); chk("R10 burst word 1", w, 32'h2468_ACE0);
      rd(8'h42, b); chk("R10 burst read step", 32'(b), 32'h12);
      wr(8'h41, 8'h00);
      set_addr(16'h0410);
      rd(8'h4F, b); rd(8'h4F, b);
      rd(8'h42, b); chk("R10 address holds without burst", 32'(b), 32'h10);
   endtask

   task automatic t_no_grant;
      logic [31:0] w;
      wr(8'h41, 8'h40);
      set_addr(16'h0406);
      read_win(w); chk("R11 window zero without grant", w, 32'h0);
      write_lanes(0, 32'hFFFF_FFFF);
      t_grant(3);
      set_addr(16'h0406);
      read_win(w); chk("R11 ungranted commit dropped", w, 32'hCCAA_2211);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      eng_write(6'd5, 32'hA5A5_5A5A);
      t_engine();
      t_lanes();
      t_range();
      t_burst();
      t_release(2);
      t_no_grant();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule